// File: doc/BRIEF.md
# Four-Lane DDR Word Serializer

This block turns four parallel 12-bit sample words into four serial bit streams, one line per lane. It runs from a fast clock at twelve times the sample rate, so a complete word leaves in exactly twelve fast cycles. All four lanes start and end their words together.

Next to the data lines it drives two clocks for the receiver. The frame clock runs at the sample rate and marks word boundaries. The bit clock runs at six times the sample rate and changes level on every fast cycle. A receiver therefore captures one bit on each bit-clock edge, rising and falling.

Two run-time controls set the output. One picks most-significant-bit-first or least-significant-bit-first order. The other replaces the sample data with one of three fixed test words. Both controls, and the sample inputs, are taken only at a word boundary. Upstream logic holds each set of samples stable for a whole conversion period.

Top module: `ddr_word_serializer`

## Requirements
- R1: Each of the four lanes sends its own 12-bit word on its own `ser_out` bit, one bit per fast cycle. All four words are captured on the same clock edge. Lane n takes its word from `sample_in[12n+11:12n]`.
- R2: When `msb_first` is 1 at capture, the word goes out starting with bit 11. Slot k carries bit 11-k.
- R3: When `msb_first` is 0 at capture, the word goes out starting with bit 0. Slot k carries bit k.
- R4: `frame_clk` is high in slots 0 to 5 and low in slots 6 to 11, which gives a period of 12 fast cycles.
- R5: `bit_clk` changes level on every fast cycle. It is high in even slots and low in odd slots, so it rises together with `frame_clk`.
- R6: The inputs are sampled on the clock edge that starts slot 0. The first bit of the word appears on that same edge, together with the rising edge of `frame_clk`.
- R7: A change of `msb_first` during a word does not affect that word. It applies from the next word.
- R8: `pat_sel` chooses the word source for all lanes. 00 selects the sample data, 01 selects 12'hFC0 (aligned with the frame clock), 10 selects 12'hAAA and 11 selects 12'h555. The chosen word is sent in the selected bit order.
- R9: Changes of `pat_sel` or `sample_in` during a word have no effect on that word. The next word uses the new values.
- R10: While `rst` is high, the register updated at each clock edge holds all `ser_out` lines, `frame_clk` and `bit_clk` low. The first edge after `rst` falls starts slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twelve times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| msb_first | input | 1 | Bit order: 1 sends the MSB first, 0 sends the LSB first |
| pat_sel | input | 2 | Word source: sample data or one of three test words |
| sample_in | input | 48 | Four 12-bit lane words, lane 0 in the low bits |
| ser_out | output | 4 | Serial data, one bit per lane |
| frame_clk | output | 1 | Word-rate clock, high for the first half of each word |
| bit_clk | output | 1 | Half-rate DDR bit clock, changes every fast cycle |

## Verification
The bound checker watches the timing skeleton on every cycle:
- the bit clock changes level each cycle;
- the frame clock holds each level for exactly six cycles;
- the frame clock rises only while the bit clock is high;
- every output is cleared after a reset cycle.

The content of the lanes can only be shown by the directed scenarios. These are the bit positions in each slot, the order of the bits and the test words. They also cover the deferral of mid-word changes to control and data, and the realignment to slot 0 after a reset in the middle of a word. The bench computes each expected bit from the word and the order that were in force at capture.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Word-source selection shared by top and bench documentation
  typedef enum logic [1:0] {
    SRC_SAMPLE  = 2'b00,
    SRC_FRAME   = 2'b01,
    SRC_TOGGLE  = 2'b10,
    SRC_TOGGLEN = 2'b11
  } src_sel_e;
endpackage

// File: rtl/ser_timing.sv
module ser_timing #(
  parameter int WORD_W = 12
) (
  input  logic clk,
  input  logic rst,
  output logic load,
  output logic frame_q,
  output logic bitclk_q
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALFC = CNT_W'(HALF);

  logic [CNT_W-1:0] slot_q;

  // slot 0 is the capture slot
  assign load = (slot_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      frame_q  <= 1'b0;
      bitclk_q <= 1'b0;
    end else begin
      slot_q   <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      frame_q  <= (slot_q < HALFC);
      bitclk_q <= ~bitclk_q;
    end
  end
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              msb_first,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_q
);
  logic [WORD_W-1:0] sr_q;
  logic              order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      order_q <= 1'b0;
      ser_q   <= 1'b0;
    end else if (load) begin
      order_q <= msb_first;
      if (msb_first) begin
        ser_q <= word_in[WORD_W-1];
        sr_q  <= {word_in[WORD_W-2:0], 1'b0};
      end else begin
        ser_q <= word_in[0];
        sr_q  <= {1'b0, word_in[WORD_W-1:1]};
      end
    end else if (order_q) begin
      ser_q <= sr_q[WORD_W-1];
      sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
    end else begin
      ser_q <= sr_q[0];
      sr_q  <= {1'b0, sr_q[WORD_W-1:1]};
    end
  end
endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
  import ser_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    msb_first,
  input  logic [1:0]              pat_sel,
  input  logic [LANES*WORD_W-1:0] sample_in,
  output logic [LANES-1:0]        ser_out,
  output logic                    frame_clk,
  output logic                    bit_clk
);
  localparam int HALF = WORD_W / 2;

  logic              load;
  logic [WORD_W-1:0] pat_frame, pat_tog, pat_togn;
  src_sel_e          src;

  assign src = src_sel_e'(pat_sel);

  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      pat_frame[i] = (i >= WORD_W - HALF);
      pat_tog[i]   = (i % 2) == 1;
      pat_togn[i]  = (i % 2) == 0;
    end
  end

  ser_timing #(.WORD_W(WORD_W)) u_timing (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .frame_q  (frame_clk),
    .bitclk_q (bit_clk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] word;
    always_comb begin
      unique case (src)
        SRC_FRAME:   word = pat_frame;
        SRC_TOGGLE:  word = pat_tog;
        SRC_TOGGLEN: word = pat_togn;
        default:     word = sample_in[g*WORD_W +: WORD_W];
      endcase
    end
    ser_lane #(.WORD_W(WORD_W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .msb_first (msb_first),
      .word_in   (word),
      .ser_q     (ser_out[g])
    );
  end
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int LANES  = 4,
  parameter int WORD_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] ser_out,
  input logic             frame_clk,
  input logic             bit_clk
);
  localparam int HALF  = WORD_W / 2;
  localparam int RUN_W = $clog2(WORD_W) + 2;

  logic             armed;
  logic             seen_q;
  logic             prev_f;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      seen_q <= 1'b0;
      prev_f <= 1'b0;
      run_q  <= '0;
    end else begin
      armed  <= 1'b1;
      prev_f <= frame_clk;
      if (frame_clk != prev_f) begin
        run_q  <= RUN_W'(1);
        seen_q <= 1'b1;
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R5: bit clock changes level every fast cycle
  p_bitclk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (bit_clk != $past(bit_clk)));

  // R5: frame clock rises only while the bit clock is high
  p_frame_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_clk) |-> bit_clk);

  // R4: each frame-clock level lasts exactly half a word
  p_frame_half_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && frame_clk != prev_f) |-> (run_q == RUN_W'(HALF)));

  // R10: a reset cycle leaves every output low
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (ser_out == '0 && !frame_clk && !bit_clk));
endmodule

bind ddr_word_serializer ser_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_out   (ser_out),
  .frame_clk (frame_clk),
  .bit_clk   (bit_clk)
);

// File: tb/ddr_word_serializer_test.sv
`timescale 1ns/1ps
module ddr_word_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msb_first = 1'b1;
  logic [1:0]  pat_sel = 2'b00;
  logic [47:0] sample_in = '0;
  logic [3:0]  ser_out;
  logic        frame_clk, bit_clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr_word_serializer uut (
    .clk(clk), .rst(rst), .msb_first(msb_first), .pat_sel(pat_sel),
    .sample_in(sample_in), .ser_out(ser_out), .frame_clk(frame_clk), .bit_clk(bit_clk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pick(input logic [47:0] d, input logic [1:0] s, input int ln);
    case (s)
      2'b01:   return 12'hFC0;
      2'b10:   return 12'hAAA;
      2'b11:   return 12'h555;
      default: return d[ln*12 +: 12];
    endcase
  endfunction

  // Called at a negedge just before slot 0. Sends one word and checks each slot.
  // At slot 5 it applies the mid-word values, which must not touch this word.
  task automatic word_run(input string req, input logic [47:0] d, input logic msb,
                          input logic [1:0] s, input logic [47:0] d_mid,
                          input logic msb_mid, input logic [1:0] s_mid);
    logic [11:0] w [4];
    sample_in = d; msb_first = msb; pat_sel = s;
    for (int l = 0; l < 4; l++) w[l] = pick(d, s, l);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); @(negedge clk);
      for (int l = 0; l < 4; l++)
        check({req, " R1 lane bit"}, ser_out[l], msb ? w[l][11-k] : w[l][k]);
      check("R4 frame_clk", frame_clk, k < 6);
      check("R5 bit_clk", bit_clk, (k % 2) == 0);
      if (k == 0) check("R6 first bit with frame rise", frame_clk, 1);
      if (k == 5) begin
        sample_in = d_mid; msb_first = msb_mid; pat_sel = s_mid;
      end
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R10 reset ser_out", ser_out, 0);
    check("R10 reset frame_clk", frame_clk, 0);
    check("R10 reset bit_clk", bit_clk, 0);
    rst = 1'b0;
  endtask

  task automatic t_msb();
    word_run("R2 msb", 48'h123_A5C_FFF_801, 1, 2'b00, 48'h123_A5C_FFF_801, 1, 2'b00);
    word_run("R2 msb2", 48'h000_7E1_3C3_9D6, 1, 2'b00, 48'h000_7E1_3C3_9D6, 1, 2'b00);
  endtask

  task automatic t_lsb();
    word_run("R3 lsb", 48'h801_F0E_234_C96, 0, 2'b00, 48'h801_F0E_234_C96, 0, 2'b00);
  endtask

  task automatic t_order_change();
    // R7: order flips mid-word; current word stays msb, next word is lsb
    word_run("R7 hold", 48'h9A1_0F3_E22_487, 1, 2'b00, 48'h9A1_0F3_E22_487, 0, 2'b00);
    word_run("R7 next", 48'h9A1_0F3_E22_487, 0, 2'b00, 48'h9A1_0F3_E22_487, 0, 2'b00);
  endtask

  task automatic t_patterns();
    word_run("R8 frame pat", 48'h111_222_333_444, 1, 2'b01, 48'h111_222_333_444, 1, 2'b01);
    word_run("R8 toggle pat", 48'h111_222_333_444, 1, 2'b10, 48'h111_222_333_444, 1, 2'b10);
    word_run("R8 toggle inv", 48'h111_222_333_444, 0, 2'b11, 48'h111_222_333_444, 0, 2'b11);
    word_run("R8 frame lsb", 48'h111_222_333_444, 0, 2'b01, 48'h111_222_333_444, 0, 2'b01);
  endtask

  task automatic t_midword_ignore();
    // R9: source and data change at slot 5 leave the word in flight untouched
    word_run("R9 hold", 48'hABC_DEF_012_345, 1, 2'b00, 48'h5A5_0F0_FFF_000, 1, 2'b10);
    word_run("R9 next pat", 48'h5A5_0F0_FFF_000, 1, 2'b10, 48'h5A5_0F0_FFF_000, 1, 2'b00);
    word_run("R9 next data", 48'h5A5_0F0_FFF_000, 1, 2'b00, 48'h5A5_0F0_FFF_000, 1, 2'b00);
  endtask

  task automatic t_reset_midword();
    for (int i = 0; i < 4; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 midword ser_out", ser_out, 0);
    check("R10 midword frame_clk", frame_clk, 0);
    check("R10 midword bit_clk", bit_clk, 0);
    rst = 1'b0;
    word_run("R10 realign", 48'hC3F_018_7E7_A00, 1, 2'b00, 48'hC3F_018_7E7_A00, 1, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    t_msb();
    t_lsb();
    t_order_change();
    t_patterns();
    t_midword_ignore();
    t_reset_midword();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule